// File: doc/BRIEF.md
# Indirect-Access General-Purpose I/O Port

This block is a 22-pin general-purpose I/O controller for a legacy-style peripheral hub. The pins form three sparse groups. Software numbers them 10–17, 20–25 and 30–37, with the tens digit naming the group and the units digit the bit. Pin levels are read and written through a pair of byte ports on an 8-bit I/O bus. One port holds an index and the other moves data for the register that index selects. A 2-bit selector chooses one of four address pairs for the two ports. An enable input decides whether the ports answer at all.

Each pin also has a small configuration register, reached through a separate configuration write port made of an index and a data byte. Configuration sets the direction, inverts the polarity in both directions, or gives the pad to an alternate function outside this block. A pin given to an alternate function drives its pad from the alternate-function signals. The raw pad level is always returned to the alternate function.

The bus is plain strobes: one write or read per cycle with no back-pressure, and read data is registered.

Top module: `gpx_port`

## Requirements
- R1: After reset every pin is an input with normal polarity and no alternate function: all `pad_oe` bits are 0, the index register is 0 and `io_rdata` is 0.
- R2: `port_sel` places the index/data port pair at 0xE0/0xE1 (0), 0xE2/0xE3 (1), 0xE4/0xE5 (2) or 0xEA/0xEB (3). When `port_en` is 0, bus writes change nothing and bus reads return 0.
- R3: A write to the index port stores the byte, and a read of the index port returns it. Data-port accesses reach pin group 1 at index 0x01, group 2 at index 0x02 and group 3 at index 0x03. With any other index, data writes are ignored and data reads return 0.
- R4: Bit n of a data register is pin group×10+n. A data write stores each bit into that pin's output latch. An output pin that is not in alternate mode drives its latch value on its pad with `pad_oe`=1.
- R5: In the group 2 data register (index 0x02), bits 7 and 6 always read 0.
- R6: In a pin configuration byte, bit 0 = 1 makes the pin an input (`pad_oe`=0), bit 1 = 1 inverts its polarity and bit 3 = 1 selects the alternate function. Bits 2 and 7–4 are ignored.
- R7: Configuration bytes for pins 10–17 sit at 0xE0–0xE7, for pins 20–25 at 0xE8–0xED and for pins 30–37 at 0xF5–0xFC. Writes to any other configuration index change nothing.
- R8: Polarity inversion applies to the value an output pin drives and to the value an input pin reads back.
- R9: A pin in alternate mode drives `pad_out` from `alt_out` and `pad_oe` from `alt_oe`. Data writes do not change its pad, and a data read returns its raw pad level.
- R10: A data read returns the (possibly inverted) pad level for input pins and the latched output value for output pins. `alt_in` always carries the raw pad levels.
- R11: `io_rdata` is registered. It shows the read result in the cycle after `io_rd` is high and is 0 in every cycle after one with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 2 | Selects the address pair of the index/data ports |
| port_en | input | 1 | Enables the index/data ports |
| io_addr | input | 8 | I/O bus address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_data | input | 8 | Configuration write data |
| pad_in | input | 22 | Pad input levels, bit 0 = pin 10, bit 8 = pin 20, bit 14 = pin 30 |
| pad_out | output | 22 | Pad output levels |
| pad_oe | output | 22 | Pad output enables |
| alt_out | input | 22 | Alternate-function output levels |
| alt_oe | input | 22 | Alternate-function output enables |
| alt_in | output | 22 | Raw pad levels returned to alternate functions |

## Verification
A wrong configuration bit changes `pad_oe` or `pad_out` of that pin in the cycle right after the configuration write. It also corrupts any later read of the pin's data register, so a random mix of configuration writes, data writes and reads exposes it within a few operations. A corrupt index register or a bad address decode shows up in the next data-port read as a zero or a stray byte. A latch that takes a write while its pin is in alternate mode stays invisible on the pad until the pin goes back to normal mode, so the random sequence switches pins out of alternate mode and then reads and checks their pads.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef struct packed {
    logic alt;
    logic inv;
    logic is_in;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{alt: 1'b0, inv: 1'b0, is_in: 1'b1};

  localparam int unsigned CFG_IN_BIT  = 0;
  localparam int unsigned CFG_INV_BIT = 1;
  localparam int unsigned CFG_ALT_BIT = 3;

  function automatic logic [7:0] index_port_addr(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'hE0;
      2'd1:    return 8'hE2;
      2'd2:    return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

endpackage

// File: rtl/gpx_port_decode.sv
module gpx_port_decode #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    port_sel,
  input  logic          port_en,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] idx_q,
  output logic          data_wr,
  output logic          data_rd,
  output logic          index_rd
);
  import gpx_pkg::*;

  logic [AW-1:0] idx_addr;
  logic [AW-1:0] dat_addr;
  logic          hit_idx;
  logic          hit_dat;

  always_comb begin
    idx_addr = AW'(index_port_addr(port_sel));
    dat_addr = idx_addr + AW'(1);
    hit_idx  = port_en && (io_addr == idx_addr);
    hit_dat  = port_en && (io_addr == dat_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (io_wr && hit_idx)
      idx_q <= io_wdata;
  end

  assign data_wr  = io_wr && hit_dat;
  assign data_rd  = io_rd && hit_dat;
  assign index_rd = io_rd && hit_idx;

endmodule

// File: rtl/gpx_pin_cell.sv
module gpx_pin_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       dat_we,
  input  logic       dat_bit,
  input  logic       pad_in,
  input  logic       alt_out,
  input  logic       alt_oe,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       rd_bit,
  output logic       is_alt,
  output logic       is_in
);
  import gpx_pkg::*;

  pin_cfg_t cfg_q;
  logic     latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_we) begin
      cfg_q.is_in <= cfg_wdata[CFG_IN_BIT];
      cfg_q.inv   <= cfg_wdata[CFG_INV_BIT];
      cfg_q.alt   <= cfg_wdata[CFG_ALT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latch_q <= 1'b0;
    else if (dat_we)
      latch_q <= dat_bit;
  end

  always_comb begin
    if (cfg_q.alt) begin
      pad_out = alt_out;
      pad_oe  = alt_oe;
      rd_bit  = pad_in;
    end else begin
      pad_out = latch_q ^ cfg_q.inv;
      pad_oe  = !cfg_q.is_in;
      rd_bit  = cfg_q.is_in ? (pad_in ^ cfg_q.inv) : latch_q;
    end
  end

  assign is_alt = cfg_q.alt;
  assign is_in  = cfg_q.is_in;

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank #(
  parameter int unsigned      N        = 8,
  parameter int unsigned      DW       = 8,
  parameter logic [7:0]       CFG_BASE = 8'hE0,
  parameter logic [7:0]       DIDX     = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_idx,
  input  logic [7:0]    cfg_data,
  input  logic          data_wr,
  input  logic [DW-1:0] idx_q,
  input  logic [DW-1:0] io_wdata,
  input  logic [N-1:0]  pad_in,
  input  logic [N-1:0]  alt_out,
  input  logic [N-1:0]  alt_oe,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  alt_vec,
  output logic [N-1:0]  in_vec,
  output logic [DW-1:0] rd_byte,
  output logic          sel_hit
);
  logic [N-1:0] rd_bits;
  logic         bank_we;

  assign sel_hit = (idx_q == DW'(DIDX));
  assign bank_we = data_wr && sel_hit;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic cfg_we_i;
    assign cfg_we_i = cfg_wr && (cfg_idx == 8'(CFG_BASE + 8'(i)));

    gpx_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we_i),
      .cfg_wdata(cfg_data),
      .dat_we   (bank_we),
      .dat_bit  (io_wdata[i]),
      .pad_in   (pad_in[i]),
      .alt_out  (alt_out[i]),
      .alt_oe   (alt_oe[i]),
      .pad_out  (pad_out[i]),
      .pad_oe   (pad_oe[i]),
      .rd_bit   (rd_bits[i]),
      .is_alt   (alt_vec[i]),
      .is_in    (in_vec[i])
    );
  end

  if (N < DW) begin : g_pad_zero
    assign rd_byte = {{(DW-N){1'b0}}, rd_bits};
  end else begin : g_full
    assign rd_byte = rd_bits;
  end

endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int unsigned G0_N   = 8,
  parameter int unsigned G1_N   = 6,
  parameter int unsigned G2_N   = 8,
  parameter logic [7:0]  G0_CFG = 8'hE0,
  parameter logic [7:0]  G1_CFG = 8'hE8,
  parameter logic [7:0]  G2_CFG = 8'hF5,
  parameter int unsigned NPIN   = G0_N + G1_N + G2_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      port_sel,
  input  logic            port_en,
  input  logic [7:0]      io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_idx,
  input  logic [7:0]      cfg_data,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic [NPIN-1:0] alt_out,
  input  logic [NPIN-1:0] alt_oe,
  output logic [NPIN-1:0] alt_in
);
  localparam int unsigned NBANK = 3;
  localparam int unsigned DW    = 8;
  localparam int unsigned BANK_N   [NBANK] = '{G0_N, G1_N, G2_N};
  localparam int unsigned BANK_OFF [NBANK] = '{0, G0_N, G0_N + G1_N};
  localparam logic [7:0]  BANK_CFG [NBANK] = '{G0_CFG, G1_CFG, G2_CFG};

  logic [DW-1:0]   idx_q;
  logic            data_wr;
  logic            data_rd;
  logic            index_rd;
  logic [DW-1:0]   bank_rd  [NBANK];
  logic [NBANK-1:0] bank_hit;
  logic [NPIN-1:0] alt_vec;
  logic [NPIN-1:0] in_vec;
  logic [DW-1:0]   data_mux;

  gpx_port_decode #(.AW(8), .DW(DW)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_sel(port_sel),
    .port_en (port_en),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .idx_q   (idx_q),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .index_rd(index_rd)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam int unsigned LO = BANK_OFF[g];
    localparam int unsigned BN = BANK_N[g];
    gpx_bank #(
      .N       (BN),
      .DW      (DW),
      .CFG_BASE(BANK_CFG[g]),
      .DIDX    (8'(g + 1))
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_idx (cfg_idx),
      .cfg_data(cfg_data),
      .data_wr (data_wr),
      .idx_q   (idx_q),
      .io_wdata(io_wdata),
      .pad_in  (pad_in [LO +: BN]),
      .alt_out (alt_out[LO +: BN]),
      .alt_oe  (alt_oe [LO +: BN]),
      .pad_out (pad_out[LO +: BN]),
      .pad_oe  (pad_oe [LO +: BN]),
      .alt_vec (alt_vec[LO +: BN]),
      .in_vec  (in_vec [LO +: BN]),
      .rd_byte (bank_rd[g]),
      .sel_hit (bank_hit[g])
    );
  end

  always_comb begin
    data_mux = '0;
    for (int g = 0; g < NBANK; g++)
      if (bank_hit[g]) data_mux = bank_rd[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      io_rdata <= '0;
    else if (index_rd)
      io_rdata <= idx_q;
    else if (data_rd)
      io_rdata <= data_mux;
    else
      io_rdata <= '0;
  end

  assign alt_in = pad_in;

endmodule

// File: rtl/gpx_port_chk.sv
module gpx_port_chk #(
  parameter int unsigned NPIN = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            io_wr,
  input logic            io_rd,
  input logic            cfg_wr,
  input logic            port_en,
  input logic [7:0]      io_rdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] alt_vec,
  input logic [NPIN-1:0] in_vec
);

  AST_RESET_NO_DRIVE: assert property (@(posedge clk) !rst_n |=> pad_oe == '0); // R1

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & in_vec & ~alt_vec) == '0); // R6

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> io_rdata == '0); // R11

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !port_en) |=> io_rdata == '0); // R2

  AST_PAD_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !cfg_wr) |=> $stable(pad_out & ~alt_vec)); // R4

endmodule

bind gpx_port gpx_port_chk #(.NPIN(NPIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_wr   (io_wr),
  .io_rd   (io_rd),
  .cfg_wr  (cfg_wr),
  .port_en (port_en),
  .io_rdata(io_rdata),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .alt_vec (alt_vec),
  .in_vec  (in_vec)
);

// File: tb/tb_gpx_port.sv
module tb_gpx_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    port_sel = 2'd3;
  logic          port_en = 1'b1;
  logic [7:0]    io_addr = '0;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_idx = '0;
  logic [7:0]    cfg_data = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] alt_out = '0;
  logic [NP-1:0] alt_oe = '0;
  logic [NP-1:0] alt_in;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit       m_in  [NP];
  bit       m_inv [NP];
  bit       m_alt [NP];
  bit       m_lat [NP];
  bit [7:0] m_idx;

  gpx_port dut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .port_en(port_en),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [7:0] idx_port(input bit [1:0] s);
    case (s)
      2'd0: return 8'hE0;
      2'd1: return 8'hE2;
      2'd2: return 8'hE4;
      default: return 8'hEA;
    endcase
  endfunction

  function automatic int cfg_pin(input bit [7:0] k);
    if (k >= 8'hE0 && k <= 8'hE7) return int'(k) - 'hE0;
    if (k >= 8'hE8 && k <= 8'hED) return 8 + int'(k) - 'hE8;
    if (k >= 8'hF5 && k <= 8'hFC) return 14 + int'(k) - 'hF5;
    return -1;
  endfunction

  function automatic int bank_lo(input int r);
    return (r == 1) ? 0 : (r == 2) ? 8 : 14;
  endfunction

  function automatic int bank_n(input int r);
    return (r == 2) ? 6 : 8;
  endfunction

  function automatic bit [NP-1:0] exp_oe();
    bit [NP-1:0] v;
    for (int p = 0; p < NP; p++)
      v[p] = m_alt[p] ? alt_oe[p] : !m_in[p];
    return v;
  endfunction

  function automatic bit [NP-1:0] exp_out();
    bit [NP-1:0] v;
    for (int p = 0; p < NP; p++)
      v[p] = m_alt[p] ? alt_out[p] : (m_lat[p] ^ m_inv[p]);
    return v;
  endfunction

  function automatic bit [7:0] exp_data();
    bit [7:0] v = '0;
    int r = int'(m_idx);
    if (r < 1 || r > 3) return 8'h00;
    for (int n = 0; n < bank_n(r); n++) begin
      int p = bank_lo(r) + n;
      if (m_alt[p])     v[n] = pad_in[p];
      else if (m_in[p]) v[n] = pad_in[p] ^ m_inv[p];
      else              v[n] = m_lat[p];
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pads(input string req);
    check(req, 32'(pad_oe), 32'(exp_oe()));
    check(req, 32'(pad_out & pad_oe), 32'(exp_out() & exp_oe()));
    check(req, 32'(alt_in), 32'(pad_in));
  endtask

  task automatic model_io_write(input bit [7:0] a, input bit [7:0] d);
    bit [7:0] ia = idx_port(port_sel);
    if (!port_en) return;
    if (a == ia) m_idx = d;
    else if (a == ia + 8'd1) begin
      int r = int'(m_idx);
      if (r >= 1 && r <= 3)
        for (int n = 0; n < bank_n(r); n++) m_lat[bank_lo(r) + n] = d[n];
    end
  endtask

  task automatic io_write(input bit [7:0] a, input bit [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    model_io_write(a, d);
  endtask

  task automatic io_read(input bit [7:0] a, output bit [7:0] exp, output logic [7:0] act);
    bit [7:0] ia;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    ia = idx_port(port_sel);
    if (!port_en) exp = 8'h00;
    else if (a == ia) exp = m_idx;
    else if (a == ia + 8'd1) exp = exp_data();
    else exp = 8'h00;
    @(negedge clk);
    io_rd = 1'b0;
    act = io_rdata;
  endtask

  task automatic cfg_write(input bit [7:0] k, input bit [7:0] d);
    int p;
    @(negedge clk);
    cfg_idx = k; cfg_data = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    p = cfg_pin(k);
    if (p >= 0) begin
      m_in[p] = d[0]; m_inv[p] = d[1]; m_alt[p] = d[3];
    end
  endtask

  task automatic read_data_chk(input string req);
    bit [7:0] e; logic [7:0] a;
    io_read(idx_port(port_sel) + 8'd1, e, a);
    check(req, 32'(a), 32'(e));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit [7:0] e; logic [7:0] a;
    void'($urandom(32'h5EED_1234));
    for (int p = 0; p < NP; p++) begin
      m_in[p] = 1; m_inv[p] = 0; m_alt[p] = 0; m_lat[p] = 0;
    end
    m_idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 oe", 32'(pad_oe), 32'h0);
    check("R1 rdata", 32'(io_rdata), 32'h0);
    rst_n = 1'b1;
    pad_in = 22'h2A5A5A;
    io_read(8'hEA, e, a); check("R1 index", 32'(a), 32'h0);

    // R3/R10: read group 1 inputs
    io_write(8'hEA, 8'h01);
    read_data_chk("R10 input read");
    io_write(8'hEA, 8'h07);
    read_data_chk("R3 bad index read");

    // R2: each port pair
    for (int s = 0; s < 4; s++) begin
      port_sel = 2'(s);
      io_write(idx_port(2'(s)), 8'h03);
      io_read(idx_port(2'(s)), e, a); check("R2 pair", 32'(a), 32'h03);
    end
    port_en = 1'b0;
    io_write(8'hEA, 8'h02);
    io_read(8'hEA, e, a); check("R2 disabled read", 32'(a), 32'h0);
    port_en = 1'b1;
    io_read(8'hEA, e, a); check("R2 disabled write ignored", 32'(a), 32'h03);

    // R4/R5: make group 2 outputs, write all ones
    for (int k = 'hE8; k <= 'hED; k++) cfg_write(8'(k), 8'h00);
    io_write(8'hEA, 8'h02);
    io_write(8'hEB, 8'hFF);
    check_pads("R4 outputs");
    check("R4 pin20-25 oe", 32'(pad_oe[13:8]), 32'h3F);
    read_data_chk("R5 unused bits");
    io_read(8'hEB, e, a); check("R5 bits76", 32'(a[7:6]), 32'h0);

    // R6/R8: inverted output and inverted input
    cfg_write(8'hE9, 8'hF6);            // pin 21: output, inverted, junk unused bits
    check("R8 inverted output", 32'(pad_out[9]), 32'h0);
    cfg_write(8'hF5, 8'h03);            // pin 30: input, inverted
    io_write(8'hEA, 8'h03);
    read_data_chk("R8 inverted input");

    // R7: unmapped configuration indices
    cfg_write(8'hEE, 8'h00); cfg_write(8'hF4, 8'h00); cfg_write(8'hFD, 8'h00);
    cfg_write(8'hDF, 8'h00);
    check_pads("R7 unmapped cfg");

    // R9: alternate function on pin 22
    alt_out = '1; alt_oe = 22'h000400;
    cfg_write(8'hEA, 8'h08);
    io_write(8'hEA, 8'h02);
    io_write(8'hEB, 8'h00);
    check("R9 alt pad", 32'(pad_out[10]), 32'h1);
    check("R9 alt oe", 32'(pad_oe[10]), 32'h1);
    read_data_chk("R9 alt read");

    // R11 plus random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 5);
      @(negedge clk);
      pad_in  = NP'($urandom);
      alt_out = NP'($urandom);
      alt_oe  = NP'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        port_sel = 2'($urandom);
        port_en  = ($urandom_range(0, 9) != 0);
      end
      case (op)
        0: cfg_write(8'($urandom_range('hDE, 'hFF)), 8'($urandom));
        1: io_write(idx_port(port_sel), 8'($urandom_range(0, 4)));
        2: io_write(idx_port(port_sel) + 8'd1, 8'($urandom));
        3: read_data_chk("R10 random read");
        4: begin
             io_read(8'($urandom_range('hE0, 'hEF)), e, a);
             check("R3 random addr read", 32'(a), 32'(e));
           end
        default: begin
             @(negedge clk);
             check("R11 idle rdata", 32'(io_rdata), 32'h0);
           end
      endcase
      check_pads("R9 random pads");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule